// File: doc/BRIEF.md
# Quarter-Rate Quadrature Mixer

This block is the front stage of a digital down-converter for the case where the carrier lies at exactly one quarter of the sample rate. At that ratio the cosine and sine sequences take only the values +1, 0 and -1. Mixing therefore reduces to choosing, for each path, between an all-zero word, the sample itself and its two's-complement negation. No multiplier and no sine table are needed.

A 2-bit phase counter advances once per accepted sample. Its value steers both the in-phase lane and the quadrature lane. Each lane registers its result on the rising clock edge, so select changes cannot cause glitches at the outputs. An output-valid strobe marks the cycle that follows each accepted sample. Decimation filtering comes after this block and is not part of it.

Top module: `qmix_quarter`

## Requirements
- R1: The in-phase output equals the sample times +1, 0, -1, 0 at phases 0, 1, 2, 3. The phase is 0 for the first accepted sample after reset and wraps from 3 back to 0.
- R2: The quadrature output equals the sample times 0, -1, 0, +1 at phases 0, 1, 2, 3, using the same phase count as the in-phase lane.
- R3: A lane whose coefficient is 0 in the current phase produces an all-zero word.
- R4: Negation is two's complement, except that negating the most negative value -2^(DATA_W-1) gives the most positive value 2^(DATA_W-1)-1 instead of wrapping.
- R5: `out_vld` equals `in_vld` from one clock earlier. `out_i` and `out_q` show the result for a sample accepted at one rising edge from that edge onward.
- R6: A cycle with `in_vld` low leaves `out_i`, `out_q` and the phase count unchanged, whatever value `in_smp` carries.
- R7: Asserting `rst_n` low clears `out_i`, `out_q` and `out_vld` to zero at once and returns the phase to 0. Release takes effect after a two-flop synchronizer, so `in_vld` is honored from the third rising edge after `rst_n` rises.
- R8: On every cycle where `out_vld` is high, at least one of `out_i` and `out_q` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_vld | input | 1 | High when `in_smp` carries a sample to be mixed |
| in_smp | input | DATA_W | Signed two's-complement input sample |
| out_vld | output | 1 | High one clock after an accepted sample |
| out_i | output | DATA_W | Signed in-phase mixer result |
| out_q | output | DATA_W | Signed quadrature mixer result |

## Verification
The bench builds the mixer with DATA_W set to 6. With that width, every input code from -32 to +31 can be driven at every one of the four phases, about 256 mixed samples in total. The sweep therefore reaches the saturating negation of -32 on both lanes and every sign and zero combination. It also includes idle cycles carrying junk samples, which must not move the outputs or the phase, and a reset in mid-stream that must restart the phase at 0.

// File: rtl/qmix_pkg.sv
package qmix_pkg;

  localparam int unsigned PHASE_W = 2;

  typedef enum logic [1:0] {
    COEF_ZERO = 2'd0,
    COEF_POS  = 2'd1,
    COEF_NEG  = 2'd2
  } coef_e;

  typedef enum logic {
    PATH_I = 1'b0,
    PATH_Q = 1'b1
  } path_e;

  // Coefficient for a lane at a given phase of the quarter-rate carrier.
  function automatic coef_e coef_of(path_e path, logic [PHASE_W-1:0] ph);
    coef_e c;
    if (path == PATH_I) begin
      case (ph)
        2'd0:    c = COEF_POS;
        2'd2:    c = COEF_NEG;
        default: c = COEF_ZERO;
      endcase
    end else begin
      case (ph)
        2'd1:    c = COEF_NEG;
        2'd3:    c = COEF_POS;
        default: c = COEF_ZERO;
      endcase
    end
    return c;
  endfunction

endpackage

// File: rtl/qmix_rst_sync.sv
module qmix_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_nxt;

  always_comb begin
    sync_nxt = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_nxt;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/qmix_phase_ctr.sv
module qmix_phase_ctr
  import qmix_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               adv,
  output logic [PHASE_W-1:0] phase
);

  logic [PHASE_W-1:0] phase_q;
  logic [PHASE_W-1:0] phase_nxt;

  always_comb begin
    phase_nxt = phase_q;
    if (adv) begin
      phase_nxt = phase_q + {{(PHASE_W-1){1'b0}}, 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_nxt;
    end
  end

  assign phase = phase_q;

endmodule

// File: rtl/qmix_lane.sv
module qmix_lane
  import qmix_pkg::*;
#(
  parameter int unsigned DATA_W = 14,
  parameter path_e       PATH   = PATH_I
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic [PHASE_W-1:0]       phase,
  input  logic signed [DATA_W-1:0] smp,
  output logic signed [DATA_W-1:0] dat
);

  localparam logic signed [DATA_W-1:0] SMIN = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic signed [DATA_W-1:0] SMAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0]        ONE  = {{(DATA_W-1){1'b0}}, 1'b1};

  coef_e                     coef;
  logic signed [DATA_W-1:0]  neg_sat;
  logic signed [DATA_W-1:0]  dat_nxt;
  logic signed [DATA_W-1:0]  dat_q;

  always_comb begin
    coef = coef_of(PATH, phase);
  end

  // Two's-complement negation that clamps the single overflow case.
  always_comb begin
    if (smp == SMIN) begin
      neg_sat = SMAX;
    end else begin
      neg_sat = ~smp + ONE;
    end
  end

  always_comb begin
    case (coef)
      COEF_POS: dat_nxt = smp;
      COEF_NEG: dat_nxt = neg_sat;
      default:  dat_nxt = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q <= '0;
    end else if (en) begin
      dat_q <= dat_nxt;
    end
  end

  assign dat = dat_q;

endmodule

// File: rtl/qmix_quarter.sv
module qmix_quarter
  import qmix_pkg::*;
#(
  parameter int unsigned DATA_W = 14
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_vld,
  input  logic signed [DATA_W-1:0] in_smp,
  output logic                     out_vld,
  output logic signed [DATA_W-1:0] out_i,
  output logic signed [DATA_W-1:0] out_q
);

  localparam int unsigned N_LANES = 2;

  logic                     rst_core_n;
  logic [PHASE_W-1:0]       phase;
  logic signed [DATA_W-1:0] lane_dat [N_LANES];
  logic                     vld_q;
  logic                     vld_nxt;

  qmix_rst_sync #(
    .STAGES (2)
  ) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  qmix_phase_ctr u_phase (
    .clk   (clk),
    .rst_n (rst_core_n),
    .adv   (in_vld),
    .phase (phase)
  );

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    qmix_lane #(
      .DATA_W (DATA_W),
      .PATH   (path_e'(g))
    ) u_lane (
      .clk   (clk),
      .rst_n (rst_core_n),
      .en    (in_vld),
      .phase (phase),
      .smp   (in_smp),
      .dat   (lane_dat[g])
    );
  end

  always_comb begin
    vld_nxt = in_vld;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_nxt;
    end
  end

  assign out_vld = vld_q;
  assign out_i   = lane_dat[0];
  assign out_q   = lane_dat[1];

endmodule

// File: rtl/qmix_quarter_chk.sv
module qmix_quarter_chk #(
  parameter int unsigned DATA_W = 14
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_vld,
  input logic signed [DATA_W-1:0] in_smp,
  input logic                     out_vld,
  input logic signed [DATA_W-1:0] out_i,
  input logic signed [DATA_W-1:0] out_q
);

  localparam logic signed [DATA_W-1:0] SMIN = {1'b1, {(DATA_W-1){1'b0}}};

  // Set once a full clock has passed out of reset, so $past is meaningful.
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
    end else begin
      armed <= 1'b1;
    end
  end

  // R7
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_clear_chk: assert (out_vld == 1'b0 && out_i == '0 && out_q == '0)
        else $error("outputs not cleared in reset");
    end
  end

  // R5
  vld_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (out_vld == $past(in_vld)));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(in_vld)) |-> ($stable(out_i) && $stable(out_q)));

  // R8
  lanes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> (out_i == '0 || out_q == '0));

  // R4
  no_wrap_i_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(in_vld) && out_i == SMIN) |-> ($past(in_smp) == SMIN));

  // R4
  no_wrap_q_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(in_vld) && out_q == SMIN) |-> ($past(in_smp) == SMIN));

endmodule

bind qmix_quarter qmix_quarter_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_core_n),
  .in_vld  (in_vld),
  .in_smp  (in_smp),
  .out_vld (out_vld),
  .out_i   (out_i),
  .out_q   (out_q)
);

// File: tb/qmix_quarter_bench.sv
module qmix_quarter_bench;

  localparam int unsigned W    = 6;
  localparam int          VMIN = -(1 << (W - 1));
  localparam int          VMAX = (1 << (W - 1)) - 1;

  logic                clk;
  logic                rst_n;
  logic                in_vld;
  logic signed [W-1:0] in_smp;
  logic                out_vld;
  logic signed [W-1:0] out_i;
  logic signed [W-1:0] out_q;

  int checks;
  int errors;
  int ph;
  int e_i;
  int e_q;
  int ci [4];
  int cq [4];

  qmix_quarter #(.DATA_W(W)) u_qmix_quarter (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (in_vld),
    .in_smp  (in_smp),
    .out_vld (out_vld),
    .out_i   (out_i),
    .out_q   (out_q)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int sat(int x);
    if (x > VMAX) return VMAX;
    if (x < VMIN) return VMIN;
    return x;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Drive one cycle at a falling edge, check the result at the next one.
  task automatic step(logic v, logic signed [W-1:0] s);
    int    x;
    string ti;
    string tq;
    in_vld = v;
    in_smp = s;
    @(negedge clk);
    x = int'(s);
    if (v) begin
      e_i = sat(x * ci[ph]);
      e_q = sat(x * cq[ph]);
      if (ci[ph] == 0)                  ti = "R3 I zero coefficient";
      else if (ci[ph] < 0 && x == VMIN) ti = "R4 I saturated negation";
      else                              ti = "R1 I path";
      if (cq[ph] == 0)                  tq = "R3 Q zero coefficient";
      else if (cq[ph] < 0 && x == VMIN) tq = "R4 Q saturated negation";
      else                              tq = "R2 Q path";
      ph = (ph + 1) % 4;
    end else begin
      ti = "R6 I hold on idle";
      tq = "R6 Q hold on idle";
    end
    chk(ti, int'(out_i), e_i);
    chk(tq, int'(out_q), e_q);
    chk("R5 valid delay", int'(out_vld), int'(v));
    if (v) chk("R8 one lane zero", int'(out_i != 0 && out_q != 0), 0);
  endtask

  task automatic reset_and_check();
    in_vld = 1'b0;
    rst_n  = 1'b0;
    @(negedge clk);
    chk("R7 reset out_i", int'(out_i), 0);
    chk("R7 reset out_q", int'(out_q), 0);
    chk("R7 reset out_vld", int'(out_vld), 0);
    ph  = 0;
    e_i = 0;
    e_q = 0;
    rst_n = 1'b1;
    // Synchronizer window plus one: idle cycles with junk data.
    for (int k = 0; k < 3; k++) step(1'b0, W'(k + 11));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    checks = 0;
    errors = 0;
    ci = '{1, 0, -1, 0};
    cq = '{0, -1, 0, 1};
    in_smp = '0;
    in_vld = 1'b0;
    rst_n  = 1'b0;
    repeat (2) @(negedge clk);
    reset_and_check();

    // Every code at every phase, with idle cycles mixed in.
    for (int v = VMIN; v <= VMAX; v++) begin
      if ((v % 5) == 0) step(1'b0, W'(~v));
      for (int r = 0; r < 4; r++) step(1'b1, W'(v));
    end

    // Leave the phase mid-sequence, then reset: phase must restart at 0 (R7).
    step(1'b1, W'(7));
    step(1'b1, W'(-9));
    reset_and_check();
    step(1'b1, W'(9));
    chk("R7 phase restart I", int'(out_i), 9);
    step(1'b1, W'(VMIN));
    step(1'b1, W'(VMIN));
    step(1'b1, W'(VMIN));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule